// File: doc/BRIEF.md
# Timed Load-Reservation Arbiter for Two Cores

This block tracks load-reserved / store-conditional reservations for two cores that share memory. When a core issues a load-reserved (LR), it gains a reservation on that address. A window counter starts at `WINDOW` and drops by one each time that core retires an instruction. A store-conditional (SC) from the holder succeeds while the window is open. If the other core issues an LR to the reserved address, the existing reservation is kept and the requester is frozen. The frozen core receives the reservation, with a fresh window, in the same cycle the holder's reservation ends. A reservation ends in one of three ways: a successful SC, a failed SC, or window expiry.

Each core has its own copy of a three-state machine. RS_IDLE means the core holds nothing. RS_HOLD means it owns a live reservation and its window counter is running. RS_WAIT means it is stalled behind the peer.

The transitions are:

- IDLE to HOLD: an LR that nothing blocks (the grant).
- IDLE to WAIT: an LR that the peer's live reservation blocks (the park). The same transition occurs when the peer takes the same address in the same cycle.
- HOLD to IDLE: an SC of any outcome, or the retire that empties the window (the release).
- WAIT to HOLD: the peer releases (the hand-over).

Caches, coherence traffic and the memory data path are outside the block.

Top module: `lrsc_timed_arbiter`

## Requirements
- R1: After reset, `stall_o` and `sc_done_o` read zero for both cores.
- R2: An LR to an address that no core reserves grants a reservation. An SC to the same address in the following cycles then returns `sc_done_o`=1 with `sc_fail_o`=0. The result is registered and is seen one edge after the SC is sampled.
- R3: An LR from one core to the address the other core holds, while that window is live, sets the requester's `stall_o` from the next edge. The holder's reservation is left intact.
- R4: When the holder's SC succeeds, the stalled core's `stall_o` falls at the same edge that the SC result appears. The released core then owns the address with a fresh window, so its SC succeeds.
- R5: The window ends on the `WINDOW`-th retire (64 by default) that the holder makes after its grant. At that edge any stalled core is released. A later SC from the expired core returns `sc_fail_o`=1 (nonzero status).
- R6: An SC from the holder to an address other than the reserved one fails. It ends the reservation and releases any stalled core at the same edge.
- R7: An LR from the non-holding core to a different address does not stall. It takes its own independent reservation.
- R8: An SC from a core that holds no reservation fails and leaves the other core's reservation untouched.
- R9: If both cores issue an LR to the same free address in the same cycle, core 0 is granted and core 1 stalls. The two cores are never stalled together.
- R10: While a core is stalled, its LR, SC and retire inputs are ignored, and no SC result is produced for it.
- R11: An LR from a core that already holds a reservation is ignored. The window is not re-armed.
- R12: An SC issued in the same cycle as the retire that would empty the window is evaluated first and succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_i | input | 2 | Per-core load-reserved strobe (bit n = core n) |
| sc_i | input | 2 | Per-core store-conditional strobe; takes precedence over `lr_i` of the same core |
| retire_i | input | 2 | Per-core instruction-retire tick |
| addr0_i | input | AW | Address carried by core 0's LR/SC |
| addr1_i | input | AW | Address carried by core 1's LR/SC |
| stall_o | output | 2 | Per-core stall, high while that core waits for the peer's reservation |
| sc_done_o | output | 2 | One-cycle pulse: an SC from that core has been resolved |
| sc_fail_o | output | 2 | Valid with `sc_done_o`; 1 = SC failed (nonzero status), 0 = success |

## Verification
Every result of this block is due one clock edge after the request that caused it. The SC outcome, the onset of a stall and the release of a stall all come from registers loaded at the edge that samples the strobe, and no registered output takes a second cycle. The bench drives one request set per cycle at the falling edge. For each cycle it queues the stall, done and fail values the requirements predict after the next rising edge. A monitor compares those values a short delay after that edge. Window expiry is timed by issuing exactly `WINDOW` retires and expecting the stall to drop on the last one and not before.

// File: rtl/lrsc_arb_pkg.sv
package lrsc_arb_pkg;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HOLD = 2'd1,
        RS_WAIT = 2'd2
    } rsv_state_e;

    localparam int unsigned NUM_CORES = 2;

endpackage

// File: rtl/lrsc_window_ctr.sv
module lrsc_window_ctr #(
    parameter int unsigned WINDOW = 64,
    localparam int unsigned CW    = $clog2(WINDOW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          dec_i,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CW'(WINDOW);
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/lrsc_core_fsm.sv
module lrsc_core_fsm
    import lrsc_arb_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned WINDOW   = 64,
    parameter bit          PRIO_LOW = 1'b1,
    localparam int unsigned CW      = $clog2(WINDOW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lr_i,
    input  logic          sc_i,
    input  logic          retire_i,
    input  logic [AW-1:0] addr_i,
    input  logic          peer_hold_i,
    input  logic          peer_leave_i,
    input  logic          peer_take_i,
    input  logic [AW-1:0] peer_res_addr_i,
    input  logic [AW-1:0] peer_req_addr_i,
    output logic          hold_o,
    output logic          stall_o,
    output logic          take_o,
    output logic          leave_o,
    output logic [AW-1:0] res_addr_o,
    output logic          sc_done_o,
    output logic          sc_fail_o
);

    rsv_state_e    state_q, state_d;
    logic [AW-1:0] res_addr_q;
    logic          ctr_load, ctr_dec, ctr_last;
    logic [CW-1:0] ctr_cnt;
    logic          blocked_hold, blocked_take, blocked;
    logic          lr_only, sc_hit;
    logic          done_d, fail_d;
    logic          done_q, fail_q;

    // Conflict detection against the peer's live or incoming reservation
    assign blocked_hold = peer_hold_i && !peer_leave_i && (peer_res_addr_i == addr_i);
    assign blocked_take = !PRIO_LOW && peer_take_i && (peer_req_addr_i == addr_i);
    assign blocked      = blocked_hold || blocked_take;
    assign lr_only      = lr_i && !sc_i;
    assign sc_hit       = sc_i && (res_addr_q == addr_i);

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: begin
                if (lr_only) begin
                    state_d = blocked ? RS_WAIT : RS_HOLD;   // park or grant
                end
            end
            RS_HOLD: begin
                if (sc_i || (retire_i && ctr_last)) begin
                    state_d = RS_IDLE;                       // release
                end
            end
            RS_WAIT: begin
                if (peer_leave_i || !peer_hold_i) begin
                    state_d = RS_HOLD;                       // hand-over
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // State register and reserved address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RS_IDLE;
            res_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == RS_IDLE) && lr_only) begin
                res_addr_q <= addr_i;
            end
        end
    end

    // Window counter control
    assign ctr_load = (state_d == RS_HOLD) && (state_q != RS_HOLD);
    assign ctr_dec  = (state_q == RS_HOLD) && retire_i && !sc_i;

    lrsc_window_ctr #(
        .WINDOW (WINDOW)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ctr_load),
        .dec_i  (ctr_dec),
        .cnt_o  (ctr_cnt),
        .last_o (ctr_last)
    );

    // SC outcome, resolved in the cycle the SC is sampled
    always_comb begin
        done_d = 1'b0;
        fail_d = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                done_d = sc_i;
                fail_d = sc_i;
            end
            RS_HOLD: begin
                done_d = sc_i;
                fail_d = sc_i && !sc_hit;
            end
            RS_WAIT: begin
                done_d = 1'b0;
                fail_d = 1'b0;
            end
            default: begin
                done_d = 1'b0;
                fail_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= done_d;
            fail_q <= fail_d;
        end
    end

    // Output decode
    always_comb begin
        hold_o     = (state_q == RS_HOLD) && (ctr_cnt != '0);
        stall_o    = (state_q == RS_WAIT);
        take_o     = (state_q == RS_IDLE) && lr_only && !blocked;
        leave_o    = (state_q == RS_HOLD) && (sc_i || (retire_i && ctr_last));
        res_addr_o = res_addr_q;
        sc_done_o  = done_q;
        sc_fail_o  = fail_q;
    end

endmodule

// File: rtl/lrsc_timed_arbiter.sv
module lrsc_timed_arbiter
    import lrsc_arb_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned WINDOW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    lr_i,
    input  logic [1:0]    sc_i,
    input  logic [1:0]    retire_i,
    input  logic [AW-1:0] addr0_i,
    input  logic [AW-1:0] addr1_i,
    output logic [1:0]    stall_o,
    output logic [1:0]    sc_done_o,
    output logic [1:0]    sc_fail_o
);

    logic [AW-1:0] req_addr_w [NUM_CORES];
    logic [AW-1:0] res_addr_w [NUM_CORES];
    logic          hold_w     [NUM_CORES];
    logic          leave_w    [NUM_CORES];
    logic          take_w     [NUM_CORES];

    assign req_addr_w[0] = addr0_i;
    assign req_addr_w[1] = addr1_i;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        localparam int P = NUM_CORES - 1 - g;

        lrsc_core_fsm #(
            .AW       (AW),
            .WINDOW   (WINDOW),
            .PRIO_LOW (g == 0)
        ) u_fsm (
            .clk             (clk),
            .rst_n           (rst_n),
            .lr_i            (lr_i[g]),
            .sc_i            (sc_i[g]),
            .retire_i        (retire_i[g]),
            .addr_i          (req_addr_w[g]),
            .peer_hold_i     (hold_w[P]),
            .peer_leave_i    (leave_w[P]),
            .peer_take_i     (take_w[P]),
            .peer_res_addr_i (res_addr_w[P]),
            .peer_req_addr_i (req_addr_w[P]),
            .hold_o          (hold_w[g]),
            .stall_o         (stall_o[g]),
            .take_o          (take_w[g]),
            .leave_o         (leave_w[g]),
            .res_addr_o      (res_addr_w[g]),
            .sc_done_o       (sc_done_o[g]),
            .sc_fail_o       (sc_fail_o[g])
        );
    end

endmodule

// File: rtl/lrsc_timed_arbiter_chk.sv
module lrsc_timed_arbiter_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    stall,
    input logic [1:0]    done,
    input logic [1:0]    fail,
    input logic          hold0,
    input logic          hold1,
    input logic [AW-1:0] res0,
    input logic [AW-1:0] res1
);

    // R9: the two cores are never stalled together
    a_r9_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall[0] && stall[1]));

    // R2: a failure flag only appears with a result pulse
    a_r2_fail_core0: assert property (@(posedge clk) disable iff (!rst_n)
        fail[0] |-> done[0]);
    a_r2_fail_core1: assert property (@(posedge clk) disable iff (!rst_n)
        fail[1] |-> done[1]);

    // R10: a stalled core produces no SC result
    a_r10_quiet_core0: assert property (@(posedge clk) disable iff (!rst_n)
        stall[0] |=> !done[0]);
    a_r10_quiet_core1: assert property (@(posedge clk) disable iff (!rst_n)
        stall[1] |=> !done[1]);

    // R3: a stalled core always has a live holder on the other side
    a_r3_holder_present0: assert property (@(posedge clk) disable iff (!rst_n)
        stall[0] |-> hold1);
    a_r3_holder_present1: assert property (@(posedge clk) disable iff (!rst_n)
        stall[1] |-> hold0);

    // R4: a released core owns the reservation at once
    a_r4_handover0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall[0]) |-> hold0);
    a_r4_handover1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall[1]) |-> hold1);

    // R9: never two live reservations on the same address
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (hold0 && hold1) |-> (res0 != res1));

endmodule

bind lrsc_timed_arbiter lrsc_timed_arbiter_chk #(.AW(AW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .stall (stall_o),
    .done  (sc_done_o),
    .fail  (sc_fail_o),
    .hold0 (hold_w[0]),
    .hold1 (hold_w[1]),
    .res0  (res_addr_w[0]),
    .res1  (res_addr_w[1])
);

// File: tb/lrsc_timed_arbiter_tb.sv
module lrsc_timed_arbiter_tb;

    localparam int AW     = 32;
    localparam int WINDOW = 64;
    localparam logic [AW-1:0] A = 32'h0000_0100;
    localparam logic [AW-1:0] B = 32'h0000_0200;
    localparam logic [AW-1:0] C = 32'h0000_0300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    lr_i = '0, sc_i = '0, retire_i = '0;
    logic [AW-1:0] addr0_i = '0, addr1_i = '0;
    logic [1:0]    stall_o, sc_done_o, sc_fail_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0] stall;
        logic [1:0] done;
        logic [1:0] fail;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    lrsc_timed_arbiter #(.AW(AW), .WINDOW(WINDOW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lr_i      (lr_i),
        .sc_i      (sc_i),
        .retire_i  (retire_i),
        .addr0_i   (addr0_i),
        .addr1_i   (addr1_i),
        .stall_o   (stall_o),
        .sc_done_o (sc_done_o),
        .sc_fail_o (sc_fail_o)
    );

    task automatic cmp(input string what, input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Driver: one request set per cycle, expected outputs after the next rising edge
    task automatic step(input logic [1:0] lr, input logic [1:0] sc, input logic [1:0] ret,
                        input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                        input logic [1:0] es, input logic [1:0] ed, input logic [1:0] ef,
                        input string tag);
        exp_t it;
        @(negedge clk);
        lr_i = lr; sc_i = sc; retire_i = ret; addr0_i = a0; addr1_i = a1;
        it.stall = es; it.done = ed; it.fail = ef; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares a short delay after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                cmp("stall", it.tag, stall_o, it.stall);
                cmp("sc_done", it.tag, sc_done_o, it.done);
                cmp("sc_fail", it.tag, sc_fail_o, it.fail);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        step(2'b00, 2'b00, 2'b00, '0, '0, 2'b00, 2'b00, 2'b00, "R1");

        // R3 / R10 / R4: stall, ignored inputs while stalled, hand-over on SC success
        step(2'b01, 2'b00, 2'b00, A, '0, 2'b00, 2'b00, 2'b00, "R2");
        step(2'b10, 2'b00, 2'b00, '0, A, 2'b10, 2'b00, 2'b00, "R3");
        step(2'b00, 2'b00, 2'b01, '0, '0, 2'b10, 2'b00, 2'b00, "R3");
        step(2'b00, 2'b10, 2'b00, '0, A, 2'b10, 2'b00, 2'b00, "R10");
        step(2'b10, 2'b00, 2'b10, '0, B, 2'b10, 2'b00, 2'b00, "R10");
        step(2'b00, 2'b01, 2'b00, A, '0, 2'b00, 2'b01, 2'b00, "R4");
        step(2'b00, 2'b10, 2'b00, '0, A, 2'b00, 2'b10, 2'b00, "R4");

        // R7: independent reservations on different addresses
        step(2'b11, 2'b00, 2'b00, A, B, 2'b00, 2'b00, 2'b00, "R7");
        step(2'b00, 2'b10, 2'b00, '0, B, 2'b00, 2'b10, 2'b00, "R7");
        step(2'b00, 2'b01, 2'b00, A, '0, 2'b00, 2'b01, 2'b00, "R2");

        // R5: expiry after WINDOW retires releases the stalled core
        step(2'b01, 2'b00, 2'b00, A, '0, 2'b00, 2'b00, 2'b00, "R5");
        step(2'b10, 2'b00, 2'b00, '0, A, 2'b10, 2'b00, 2'b00, "R5");
        for (int i = 0; i < WINDOW - 1; i++)
            step(2'b00, 2'b00, 2'b01, '0, '0, 2'b10, 2'b00, 2'b00, "R5");
        step(2'b00, 2'b00, 2'b01, '0, '0, 2'b00, 2'b00, 2'b00, "R5");
        step(2'b00, 2'b01, 2'b00, A, '0, 2'b00, 2'b01, 2'b01, "R5");
        step(2'b00, 2'b10, 2'b00, '0, A, 2'b00, 2'b10, 2'b00, "R5");

        // R8: SC without a reservation fails, holder unaffected
        step(2'b01, 2'b00, 2'b00, A, '0, 2'b00, 2'b00, 2'b00, "R8");
        step(2'b00, 2'b10, 2'b00, '0, A, 2'b00, 2'b10, 2'b10, "R8");
        step(2'b00, 2'b01, 2'b00, A, '0, 2'b00, 2'b01, 2'b00, "R8");

        // R9: same-cycle tie, core 0 wins
        step(2'b11, 2'b00, 2'b00, C, C, 2'b10, 2'b00, 2'b00, "R9");
        step(2'b00, 2'b01, 2'b00, C, '0, 2'b00, 2'b01, 2'b00, "R9");
        step(2'b00, 2'b10, 2'b00, '0, C, 2'b00, 2'b10, 2'b00, "R9");

        // R6: failed SC from the holder releases the stalled core
        step(2'b01, 2'b00, 2'b00, A, '0, 2'b00, 2'b00, 2'b00, "R6");
        step(2'b10, 2'b00, 2'b00, '0, A, 2'b10, 2'b00, 2'b00, "R6");
        step(2'b00, 2'b01, 2'b00, B, '0, 2'b00, 2'b01, 2'b01, "R6");
        step(2'b00, 2'b10, 2'b00, '0, A, 2'b00, 2'b10, 2'b00, "R6");

        // R11: a repeated LR from the holder does not re-arm the window
        step(2'b01, 2'b00, 2'b00, A, '0, 2'b00, 2'b00, 2'b00, "R11");
        step(2'b10, 2'b00, 2'b00, '0, A, 2'b10, 2'b00, 2'b00, "R11");
        for (int i = 0; i < WINDOW - 4; i++)
            step(2'b00, 2'b00, 2'b01, '0, '0, 2'b10, 2'b00, 2'b00, "R11");
        step(2'b01, 2'b00, 2'b00, A, '0, 2'b10, 2'b00, 2'b00, "R11");
        for (int i = 0; i < 3; i++)
            step(2'b00, 2'b00, 2'b01, '0, '0, 2'b10, 2'b00, 2'b00, "R11");
        step(2'b00, 2'b00, 2'b01, '0, '0, 2'b00, 2'b00, 2'b00, "R11");
        step(2'b00, 2'b10, 2'b00, '0, A, 2'b00, 2'b10, 2'b00, "R11");

        // R12: SC in the same cycle as the final retire succeeds
        step(2'b01, 2'b00, 2'b00, A, '0, 2'b00, 2'b00, 2'b00, "R12");
        for (int i = 0; i < WINDOW - 1; i++)
            step(2'b00, 2'b00, 2'b01, '0, '0, 2'b00, 2'b00, 2'b00, "R12");
        step(2'b00, 2'b01, 2'b01, A, '0, 2'b00, 2'b01, 2'b00, "R12");

        step(2'b00, 2'b00, 2'b00, '0, '0, 2'b00, 2'b00, 2'b00, "R1");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard not drained actual=%0d expected=0", sb.size());
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule